// File: doc/BRIEF.md
# SPI Master Word Shift Engine

This block moves a single word across an SPI link as the bus master. A one-cycle start request captures a right-aligned transmit word, a word length, a half-period wait count, the clock polarity and phase, and two per-transfer flags. One flag suppresses the data output and the other discards the data input. The engine then produces the serial clock and the outgoing data line, samples the incoming data line, and returns the received word right-aligned together with a one-cycle completion pulse.

The engine is meant to sit under a controller that owns chip select and word sequencing. That controller issues one start per word and waits for the completion pulse. The incoming data line passes through a synchronizer before it is used. Because of this, every half period of the serial clock lasts at least three system clock cycles, even when the wait count is zero.

Top module: `spi_word_engine`

## Requirements
- R1: While rst_n is low at a rising clock edge, the engine sets sck to the current cfg_cpol level and clears mosi, busy, done and rx_word to 0.
- R2: When no transfer is running, sck follows cfg_cpol with one cycle of delay. When a transfer ends, sck is left at the polarity level captured at start.
- R3: A bit_len value from 1 to 31 selects that word length, and the value 0 selects 32 bits. Bits leave most-significant first, from tx_word[len-1] down to tx_word[0]. Bits of tx_word above len-1 have no effect. Each transfer makes exactly len leading sck edges.
- R4: With cfg_cpha=0, each bit runs in this order: the data bit is placed on mosi, one half period passes, sck moves to its active level, one half period passes, then miso is sampled in the same cycle that sck returns to idle. The first leading edge appears one half period after the start is accepted.
- R5: With cfg_cpha=1, each bit runs in this order: sck moves to its active level and the data bit is placed on mosi together, one half period passes, sck returns to idle, one more half period passes, then miso is sampled. The first leading edge appears in the cycle right after the start edge.
- R6: A half period lasts half_wait+3 clock cycles. From the accepted start edge to the edge that raises done takes exactly 2*(half_wait+3)*len cycles.
- R7: When tx_off is set at start, mosi keeps the level it had before the transfer for the whole transfer.
- R8: When rx_off is set at start, miso is ignored and rx_word ends up as 0.
- R9: rx_word holds the received bits right-aligned. The first sampled bit is at position len-1, the last at position 0, and every bit above len-1 is 0.
- R10: busy is high from the edge that accepts start until the edge that raises done. done is high for exactly one cycle, and busy is already low in that cycle.
- R11: A start request that arrives while busy is high is ignored. It neither changes the running transfer nor starts another one.
- R12: mosi changes only at the start of a bit, and only when the new bit differs from the level on mosi. Between transfers it keeps the last bit sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of sck; captured at start |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge; captured at start |
| start | input | 1 | Single-cycle transfer request, accepted only while idle |
| tx_word | input | MAX_BITS | Right-aligned word to send |
| bit_len | input | LEN_W | Word length; 0 means MAX_BITS |
| half_wait | input | WAIT_W | Extra cycles added to each half period |
| tx_off | input | 1 | Keep mosi frozen for this transfer |
| rx_off | input | 1 | Shift zeros instead of miso for this transfer |
| miso | input | 1 | Serial data from the slave (asynchronous) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | MAX_BITS | Right-aligned received word |

## Verification
The bench acts as a slave in all four clock modes. It changes miso on the clock edge where a real slave would, and it records mosi on the edge where a slave would sample it. An engine that puts data on the wrong edge therefore shows up as a shifted or corrupted word, and an engine that counts the phase wrong shows up as a first leading edge in the wrong cycle. The bench covers single-bit and full 32-bit words (length code 0), a 13-bit word with junk in the unused upper transmit bits, and a wait count of zero. An off-by-one in length decoding, masking or the period formula would change the completion cycle or the received word. The bench also checks that mosi stays frozen when tx_off is set, that rx_word reads zero when rx_off is set, and that a start issued during a transfer neither disturbs it nor causes a second done.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PH_A = 2'd1,
        ST_PH_B = 2'd2
    } phase_e;

endpackage

// File: rtl/spi_eng_sync.sv
module spi_eng_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_eng_timer.sv
module spi_eng_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = load_val;
        else if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R6: a running count only ever moves down by one
    a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
    parameter int MAX_BITS = 32,
    parameter int LEN_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [LEN_W-1:0]    shamt,
    input  logic [MAX_BITS-1:0] tx_word,
    input  logic                shift,
    input  logic                rx_bit,
    output logic                tx_next,
    output logic [MAX_BITS-1:0] rx_next
);
    logic [MAX_BITS-1:0] tx_d, tx_q;
    logic [MAX_BITS-1:0] rx_d, rx_q;
    logic [MAX_BITS-1:0] aligned;

    always_comb begin
        aligned = tx_word << shamt;
        rx_next = {rx_q[MAX_BITS-2:0], rx_bit};
        tx_d    = tx_q;
        rx_d    = rx_q;
        if (load) begin
            // first bit is driven straight from the port; keep the rest
            tx_d = aligned << 1;
            rx_d = '0;
        end else if (shift) begin
            tx_d = tx_q << 1;
            rx_d = rx_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign tx_next = tx_q[MAX_BITS-1];

    // R9: a cleared receive register starts from zero
    a_r9_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rx_q == '0));
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine #(
    parameter  int MAX_BITS    = 32,
    parameter  int WAIT_W      = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int LEN_W       = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic                start,
    input  logic [MAX_BITS-1:0] tx_word,
    input  logic [LEN_W-1:0]    bit_len,
    input  logic [WAIT_W-1:0]   half_wait,
    input  logic                tx_off,
    input  logic                rx_off,
    input  logic                miso,
    output logic                sck,
    output logic                mosi,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] rx_word
);
    import spi_eng_pkg::*;

    localparam int CNT_W = WAIT_W + 2;

    typedef struct packed {
        phase_e              ph;
        logic                sck;
        logic                mosi;
        logic                cpol;
        logic                cpha;
        logic                tx_off;
        logic                rx_off;
        logic [LEN_W-1:0]    len_idx;
        logic [LEN_W:0]      left;
        logic                busy;
        logic                done;
        logic [MAX_BITS-1:0] rx;
        logic [CNT_W-1:0]    reload;
    } eng_t;

    eng_t q, n;

    logic                miso_s;
    logic                tmr_load, tmr_zero;
    logic [CNT_W-1:0]    tmr_val, new_reload;
    logic                sh_load, sh_shift, rx_bit, tx_next;
    logic [MAX_BITS-1:0] rx_next;
    logic [LEN_W-1:0]    first_idx;
    logic                first_bit;

    spi_eng_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (miso),
        .q     (miso_s)
    );

    spi_eng_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    spi_eng_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .shamt   (~first_idx),
        .tx_word (tx_word),
        .shift   (sh_shift),
        .rx_bit  (rx_bit),
        .tx_next (tx_next),
        .rx_next (rx_next)
    );

    always_comb begin
        // length code 0 wraps to the top index, giving a full-width word
        first_idx  = bit_len - LEN_W'(1);
        first_bit  = tx_word[first_idx];
        new_reload = CNT_W'(half_wait) + CNT_W'(SYNC_STAGES);
        tmr_val    = (q.ph == ST_IDLE) ? new_reload : q.reload;
        rx_bit     = q.rx_off ? 1'b0 : miso_s;

        n        = q;
        n.done   = 1'b0;
        tmr_load = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;

        unique case (q.ph)
            ST_IDLE: begin
                n.sck = cfg_cpol;
                if (start) begin
                    n.ph      = ST_PH_A;
                    n.busy    = 1'b1;
                    n.cpol    = cfg_cpol;
                    n.cpha    = cfg_cpha;
                    n.tx_off  = tx_off;
                    n.rx_off  = rx_off;
                    n.len_idx = first_idx;
                    n.left    = {1'b0, first_idx} + (LEN_W+1)'(1);
                    n.reload  = new_reload;
                    n.sck     = cfg_cpha ? ~cfg_cpol : cfg_cpol;
                    tmr_load  = 1'b1;
                    sh_load   = 1'b1;
                    if (!tx_off) n.mosi = first_bit;
                end
            end
            ST_PH_A: begin
                if (tmr_zero) begin
                    n.sck    = ~q.sck;
                    n.ph     = ST_PH_B;
                    tmr_load = 1'b1;
                end
            end
            ST_PH_B: begin
                if (tmr_zero) begin
                    sh_shift = 1'b1;
                    n.left   = q.left - (LEN_W+1)'(1);
                    if (q.left == (LEN_W+1)'(1)) begin
                        n.ph   = ST_IDLE;
                        n.busy = 1'b0;
                        n.done = 1'b1;
                        n.sck  = q.cpol;
                        n.rx   = rx_next;
                    end else begin
                        n.ph     = ST_PH_A;
                        n.sck    = q.cpha ? ~q.cpol : q.cpol;
                        tmr_load = 1'b1;
                        if (!q.tx_off && (tx_next != q.mosi)) n.mosi = tx_next;
                    end
                end
            end
            default: n.ph = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.sck <= cfg_cpol;
        end else begin
            q <= n;
        end
    end

    assign sck     = q.sck;
    assign mosi    = q.mosi;
    assign busy    = q.busy;
    assign done    = q.done;
    assign rx_word = q.rx;

    // R10: completion is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: busy is already low while done is high
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11: busy only drops together with a completion
    a_r11_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6: sck holds while the half-period timer is still running
    a_r6_sck_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph != ST_IDLE && !tmr_zero) |=> $stable(sck));

    // R7: a transfer with the output disabled leaves mosi alone
    a_r7_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.tx_off) |=> $stable(mosi));

    // R12: mosi moves only at a bit boundary
    a_r12_mosi_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(q.ph == ST_PH_B && tmr_zero)) |=> $stable(mosi));

    // R2: idle sck tracks the polarity input one cycle later
    a_r2_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !done && !$past(start)) |-> (sck == $past(cfg_cpol)));

    // R9: nothing above the word length in the received word
    a_r9_rx_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rx_word & ~({MAX_BITS{1'b1}} >> (~q.len_idx))) == '0));
endmodule

// File: tb/spi_word_engine_tb.sv
module spi_word_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_cpol, cfg_cpha, start, tx_off, rx_off, miso;
    logic [31:0] tx_word;
    logic [4:0]  bit_len;
    logic [15:0] half_wait;
    logic        sck, mosi, busy, done;
    logic [31:0] rx_word;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    spi_word_engine u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_cpol  (cfg_cpol),
        .cfg_cpha  (cfg_cpha),
        .start     (start),
        .tx_word   (tx_word),
        .bit_len   (bit_len),
        .half_wait (half_wait),
        .tx_off    (tx_off),
        .rx_off    (rx_off),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .busy      (busy),
        .done      (done),
        .rx_word   (rx_word)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // one transfer, with the bench acting as the slave
    task automatic xfer(input bit pol, input bit pha, input int len,
                        input logic [31:0] tx, input logic [31:0] srx,
                        input int hw, input bit toff, input bit roff,
                        input bit poke, input string name);
        logic [31:0] mask, got, exp_tx, exp_rx;
        int          per, cyc, bitno, leads, first_lead, extra_done;
        bit          prev, mosi_before, seen;
        mask        = (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
        per         = hw + 3;
        got         = '0;
        bitno       = 0;
        leads       = 0;
        first_lead  = -1;
        seen        = 1'b0;
        extra_done  = 0;
        mosi_before = mosi;
        prev        = pol;
        cfg_cpol    = pol;
        cfg_cpha    = pha;
        tx_word     = tx;
        bit_len     = len[4:0];
        half_wait   = 16'(hw);
        tx_off      = toff;
        rx_off      = roff;
        miso        = pha ? 1'b0 : srx[len-1];
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 0;
        while (cyc < 20000) begin
            start = 1'b0;
            if (sck != prev) begin
                if (sck != pol) begin
                    leads++;
                    if (first_lead < 0) first_lead = cyc;
                    if (pha) miso = srx[len-1-bitno];
                    else     got[len-1-bitno] = mosi;
                end else begin
                    if (pha) got[len-1-bitno] = mosi;
                    bitno++;
                    if (!pha && bitno < len) miso = srx[len-1-bitno];
                end
            end
            prev = sck;
            if (done) begin
                seen = 1'b1;
                break;
            end
            if (poke && cyc == 3) begin
                start   = 1'b1;
                tx_word = ~tx;
                bit_len = 5'd3;
            end
            @(negedge clk);
            cyc++;
        end
        exp_tx = toff ? (mosi_before ? mask : 32'h0) : (tx & mask);
        exp_rx = roff ? 32'h0 : (srx & mask);
        chk(seen, "R10", {name, " done seen"}, seen, 1);
        chk(cyc == 2*per*len, "R6", {name, " done cycle"}, cyc, 2*per*len);
        chk(!busy, "R10", {name, " busy low with done"}, busy, 0);
        chk(first_lead == (pha ? 0 : per), pha ? "R5" : "R4",
            {name, " first leading edge"}, first_lead, pha ? 0 : per);
        chk(leads == len, "R3", {name, " leading edges"}, leads, len);
        chk(got == exp_tx, toff ? "R7" : "R3", {name, " mosi bits"}, got, exp_tx);
        chk(rx_word == exp_rx, roff ? "R8" : "R9", {name, " rx_word"}, rx_word, exp_rx);
        chk(mosi == (toff ? mosi_before : tx[0]), "R12", {name, " mosi hold"},
            mosi, toff ? mosi_before : tx[0]);
        @(negedge clk);
        chk(!done, "R10", {name, " done one cycle"}, done, 0);
        chk(sck == pol, "R2", {name, " sck idle after"}, sck, pol);
        if (poke) begin
            // R11: the request made while busy must not start anything
            for (int i = 0; i < 2*per + 6; i++) begin
                if (done || busy) extra_done++;
                @(negedge clk);
            end
            chk(extra_done == 0, "R11", {name, " no second transfer"}, extra_done, 0);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0; cfg_cpol = 1'b1; cfg_cpha = 1'b0; start = 1'b0;
        tx_word = '0; bit_len = '0; half_wait = '0; tx_off = 1'b0; rx_off = 1'b0;
        miso = 1'b0;
        repeat (4) @(negedge clk);
        chk(sck == 1'b1, "R1", "reset sck at cpol", sck, 1);
        chk(mosi == 1'b0, "R1", "reset mosi", mosi, 0);
        chk(!busy && !done, "R1", "reset busy/done", {busy, done}, 0);
        chk(rx_word == '0, "R1", "reset rx_word", rx_word, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_idle_follow();
        cfg_cpol = 1'b0;
        @(negedge clk);
        chk(sck == 1'b0, "R2", "idle sck follows 0", sck, 0);
        cfg_cpol = 1'b1;
        @(negedge clk);
        chk(sck == 1'b1, "R2", "idle sck follows 1", sck, 1);
        cfg_cpol = 1'b0;
        @(negedge clk);
        chk(sck == 1'b0, "R2", "idle sck back to 0", sck, 0);
    endtask

    task automatic test_modes();
        xfer(1'b0, 1'b0, 8,  32'h0000_00A5, 32'h0000_003C, 0, 0, 0, 0, "mode0 8b");
        xfer(1'b0, 1'b1, 8,  32'h0000_005A, 32'h0000_00C3, 2, 0, 0, 0, "mode1 8b");
        xfer(1'b1, 1'b0, 16, 32'h0000_BEEF, 32'h0000_4B2D, 1, 0, 0, 0, "mode2 16b");
        xfer(1'b1, 1'b1, 32, 32'hDEAD_BEEF, 32'h1234_5679, 0, 0, 0, 0, "mode3 32b");
    endtask

    task automatic test_lengths();
        xfer(1'b0, 1'b0, 1,  32'h0000_0001, 32'h0000_0001, 4, 0, 0, 0, "len1 mode0");
        xfer(1'b1, 1'b1, 1,  32'h0000_0000, 32'h0000_0001, 0, 0, 0, 0, "len1 mode3");
        xfer(1'b1, 1'b1, 13, 32'hFFFF_E123, 32'hFFFF_FABC, 1, 0, 0, 0, "len13 junk");
    endtask

    task automatic test_flags();
        // previous transfer left mosi high; the disabled output must keep it
        xfer(1'b0, 1'b1, 8, 32'h0000_0000, 32'h0000_0096, 0, 1, 0, 0, "tx_off");
        xfer(1'b1, 1'b0, 8, 32'h0000_0081, 32'h0000_00FF, 0, 0, 1, 0, "rx_off");
    endtask

    task automatic test_busy_start();
        xfer(1'b0, 1'b0, 6, 32'h0000_002D, 32'h0000_0015, 1, 0, 0, 1, "start while busy");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        test_reset();
        test_idle_follow();
        test_modes();
        test_lengths();
        test_flags();
        test_busy_start();
        summary();
        $finish;
    end
endmodule